// File: doc/BRIEF.md
# Hardwired Micro-Operation Control Sequencer

This block is the control unit and register datapath of a small single-accumulator processor. Memory is word addressed, with 16-bit words and 12-bit addresses. Each instruction runs as a series of timed steps. In each clock cycle one group of register transfers takes place among the program counter (PC), the memory address register (MAR), the memory buffer register (MBR), the instruction register (IR) and the accumulator (R1). The control logic is fixed, with no microprogram. A 2-bit cycle code picks one of four sequences: fetch, indirect, execute and interrupt. A step counter inside the current sequence then selects the transfers for that cycle. The execute sequence depends on the opcode.

An instruction word holds the opcode in bits 15:13, the indirect flag in bit 12 and the operand address in bits 11:0. The opcodes are 0 ADD, 1 ISZ, 2 BSA and 7 HALT. The block drives a synchronous memory port with one cycle of read latency. A read is issued during the step that loads the MAR: the address bus carries the value being loaded. The word then arrives during the following step, which is the one that loads the MBR. The phase, the step and all registers are brought out for debug.

There are four states and seven transitions. The phase codes are FETCH 00, INDIRECT 01, EXECUTE 10 and INTERRUPT 11. FETCH goes to INDIRECT when the fetched word has its indirect flag set, and to EXECUTE otherwise. INDIRECT always goes to EXECUTE. At the end of its sequence EXECUTE goes to INTERRUPT when a request is pending and interrupts are enabled, and to FETCH otherwise. EXECUTE holds for good on HALT. INTERRUPT always goes to FETCH. The step codes run from t1 = 0 to t4 = 3.

Top module: `hw_ctrl_seq`

## Requirements
- R1: After reset the phase is 00, the step is t1 (0), PC, R1 and MBR are zero, the halted output is low, and interrupts are enabled.
- R2: Fetch takes three cycles. In t1 MAR is loaded from PC. In t2 MBR is loaded with the memory word and PC is incremented. In t3 IR is loaded from MBR. The next phase is 01 when bit 12 of the word is set, and 10 when it is clear.
- R3: Indirect takes three cycles. In t1 MAR is loaded from IR bits 11:0. In t2 MBR is loaded with the memory word. In t3 IR bits 11:0 are replaced by MBR bits 11:0. The next phase is 10, and the instruction then behaves as if the fetched word had been its direct operand address.
- R4: ADD (opcode 0) takes three execute cycles. It ends with R1 equal to R1 plus the memory operand, modulo 2^16.
- R5: ISZ (opcode 1) takes four execute cycles. The operand is incremented modulo 2^16 and written back in t4. PC is incremented once more in t4 if and only if the new value is zero.
- R6: BSA (opcode 2) takes three execute cycles. The address of the next instruction is stored at the target, and PC ends at target plus one.
- R7: A request is pending when the irq input is high in the last execute cycle. If interrupts are enabled at that point, the next phase is 11, which takes three cycles. PC is stored at address 0, PC becomes 1, interrupts are disabled, and the phase then returns to 00.
- R8: While interrupts are disabled, a high irq has no effect: the execute sequence goes straight to fetch.
- R9: The step counter returns to t1 whenever the phase changes, and advances by one in every other cycle while the block is running.
- R10: The read strobe and the write strobe are never high together. A write occurs only in the execute or interrupt phase and only in the steps named above, with the address taken from MAR and the data from MBR.
- R11: HALT (opcode 7) takes one execute cycle. After it, halted is high, the phase and step hold, and no register or memory changes.
- R12: Opcodes 3 to 6 take one execute cycle and change no register other than those changed by fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request level |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read strobe; data valid on mem_rdata next cycle |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Write data (MBR) |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd |
| dbg_phase | output | 2 | Current cycle code |
| dbg_step | output | 2 | Current timing step (t1 = 0) |
| dbg_pc | output | 12 | Program counter |
| dbg_mar | output | 12 | Memory address register |
| dbg_mbr | output | 16 | Memory buffer register |
| dbg_ir | output | 16 | Instruction register |
| dbg_r1 | output | 16 | Accumulator |
| halted | output | 1 | High once HALT has executed |

## Verification
A wrong phase or step value appears on the debug outputs in the very next cycle, so the bench compares the phase and step pair against a queue of expected values on every clock. A wrong register transfer usually shows up only at the next instruction boundary, as a wrong PC, a wrong R1 or a wrong memory word. An address taken from the wrong register can stay hidden until a later instruction reads that word. For that reason the whole memory image is compared after every instruction, not only the word that was targeted.

// File: rtl/hwcs_pkg.sv
package hwcs_pkg;

    typedef enum logic [1:0] {
        PH_FETCH = 2'b00,
        PH_INDIR = 2'b01,
        PH_EXEC  = 2'b10,
        PH_INTR  = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        T1 = 2'd0,
        T2 = 2'd1,
        T3 = 2'd2,
        T4 = 2'd3
    } step_e;

    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OPC_ADD  = 3'd0;
    localparam logic [OP_W-1:0] OPC_ISZ  = 3'd1;
    localparam logic [OP_W-1:0] OPC_BSA  = 3'd2;
    localparam logic [OP_W-1:0] OPC_HALT = 3'd7;

    // one bit per register transfer or strobe, plus sequencing
    typedef struct packed {
        logic   mar_pc;
        logic   mar_ir;
        logic   mar_save;
        logic   mbr_mem;
        logic   mbr_pc;
        logic   mbr_inc;
        logic   ir_mbr;
        logic   iraddr_mbr;
        logic   pc_inc;
        logic   pc_ir;
        logic   pc_vec;
        logic   r1_add;
        logic   mem_rd;
        logic   mem_wr;
        logic   ien_clr;
        logic   halt_set;
        logic   last;
        phase_e nxt;
    } ctrl_t;

endpackage

// File: rtl/hwcs_decode.sv
module hwcs_decode
    import hwcs_pkg::*;
(
    input  phase_e          phase,
    input  step_e           step,
    input  logic [OP_W-1:0] op,
    input  logic            mbr_ind,
    input  logic            mbr_zero,
    input  logic            irq,
    input  logic            ien,
    input  logic            halted,
    output ctrl_t           ctl
);

    logic exec_done;

    always_comb begin
        ctl       = '0;
        ctl.nxt   = phase;
        exec_done = 1'b0;
        if (!halted) begin
            unique case (phase)
                PH_FETCH: begin
                    unique case (step)
                        T1: begin ctl.mar_pc = 1'b1; ctl.mem_rd = 1'b1; end
                        T2: begin ctl.mbr_mem = 1'b1; ctl.pc_inc = 1'b1; end
                        T3: begin
                            ctl.ir_mbr = 1'b1;
                            ctl.last   = 1'b1;
                            ctl.nxt    = mbr_ind ? PH_INDIR : PH_EXEC;
                        end
                        default: ;
                    endcase
                end
                PH_INDIR: begin
                    unique case (step)
                        T1: begin ctl.mar_ir = 1'b1; ctl.mem_rd = 1'b1; end
                        T2: ctl.mbr_mem = 1'b1;
                        T3: begin
                            ctl.iraddr_mbr = 1'b1;
                            ctl.last       = 1'b1;
                            ctl.nxt        = PH_EXEC;
                        end
                        default: ;
                    endcase
                end
                PH_EXEC: begin
                    unique case (op)
                        OPC_ADD: begin
                            unique case (step)
                                T1: begin ctl.mar_ir = 1'b1; ctl.mem_rd = 1'b1; end
                                T2: ctl.mbr_mem = 1'b1;
                                T3: begin ctl.r1_add = 1'b1; exec_done = 1'b1; end
                                default: ;
                            endcase
                        end
                        OPC_ISZ: begin
                            unique case (step)
                                T1: begin ctl.mar_ir = 1'b1; ctl.mem_rd = 1'b1; end
                                T2: ctl.mbr_mem = 1'b1;
                                T3: ctl.mbr_inc = 1'b1;
                                T4: begin
                                    ctl.mem_wr = 1'b1;
                                    ctl.pc_inc = mbr_zero;
                                    exec_done  = 1'b1;
                                end
                                default: ;
                            endcase
                        end
                        OPC_BSA: begin
                            unique case (step)
                                T1: begin ctl.mar_ir = 1'b1; ctl.mbr_pc = 1'b1; end
                                T2: begin ctl.pc_ir = 1'b1; ctl.mem_wr = 1'b1; end
                                T3: begin ctl.pc_inc = 1'b1; exec_done = 1'b1; end
                                default: ;
                            endcase
                        end
                        OPC_HALT: ctl.halt_set = 1'b1;
                        default:  exec_done = 1'b1;
                    endcase
                    if (exec_done) begin
                        ctl.last = 1'b1;
                        ctl.nxt  = (irq && ien) ? PH_INTR : PH_FETCH;
                    end
                end
                PH_INTR: begin
                    unique case (step)
                        T1: ctl.mbr_pc = 1'b1;
                        T2: begin ctl.mar_save = 1'b1; ctl.pc_vec = 1'b1; end
                        T3: begin
                            ctl.mem_wr  = 1'b1;
                            ctl.ien_clr = 1'b1;
                            ctl.last    = 1'b1;
                            ctl.nxt     = PH_FETCH;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/hwcs_seq.sv
module hwcs_seq
    import hwcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ctrl_t  ctl,
    output phase_e phase,
    output step_e  step,
    output logic   ien,
    output logic   halted
);

    // cycle code and timing step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_FETCH;
            step  <= T1;
        end else if (ctl.last) begin
            phase <= ctl.nxt;
            step  <= T1;
        end else if (!halted && !ctl.halt_set) begin
            step  <= step_e'(step + 2'd1);
        end
    end

    // interrupt enable and halt flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien    <= 1'b1;
            halted <= 1'b0;
        end else begin
            if (ctl.ien_clr)  ien    <= 1'b0;
            if (ctl.halt_set) halted <= 1'b1;
        end
    end

endmodule

// File: rtl/hwcs_dpath.sv
module hwcs_dpath
    import hwcs_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 12'd0,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = 12'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [OP_W-1:0]   op,
    output logic              mbr_ind,
    output logic              mbr_zero,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mbr,
    output logic [DATA_W-1:0] ir,
    output logic [DATA_W-1:0] r1
);

    localparam int                PAD_W = DATA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] ONE_A = 1;
    localparam logic [DATA_W-1:0] ONE_D = 1;

    logic [ADDR_W-1:0] mar_d;

    always_comb begin
        mar_d = mar;
        if (ctl.mar_pc)        mar_d = pc;
        else if (ctl.mar_ir)   mar_d = ir[ADDR_W-1:0];
        else if (ctl.mar_save) mar_d = SAVE_ADDR;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            r1  <= '0;
        end else begin
            mar <= mar_d;
            if (ctl.mbr_mem)      mbr <= mem_rdata;
            else if (ctl.mbr_pc)  mbr <= {{PAD_W{1'b0}}, pc};
            else if (ctl.mbr_inc) mbr <= mbr + ONE_D;
            if (ctl.ir_mbr)          ir <= mbr;
            else if (ctl.iraddr_mbr) ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];
            if (ctl.pc_inc)      pc <= pc + ONE_A;
            else if (ctl.pc_ir)  pc <= ir[ADDR_W-1:0];
            else if (ctl.pc_vec) pc <= VEC_ADDR;
            if (ctl.r1_add) r1 <= r1 + mbr;
        end
    end

    // a read carries the address being loaded so data lands in the MBR step
    assign mem_addr  = ctl.mem_rd ? mar_d : mar;
    assign mem_wdata = mbr;
    assign op        = ir[DATA_W-1 -: OP_W];
    assign mbr_ind   = mbr[ADDR_W];
    assign mbr_zero  = (mbr == '0);

endmodule

// File: rtl/hw_ctrl_seq.sv
module hw_ctrl_seq
    import hwcs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [1:0]        dbg_phase,
    output logic [1:0]        dbg_step,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [ADDR_W-1:0] dbg_mar,
    output logic [DATA_W-1:0] dbg_mbr,
    output logic [DATA_W-1:0] dbg_ir,
    output logic [DATA_W-1:0] dbg_r1,
    output logic              halted
);

    ctrl_t           ctl;
    phase_e          phase;
    step_e           step;
    logic            ien;
    logic [OP_W-1:0] op;
    logic            mbr_ind;
    logic            mbr_zero;

    hwcs_seq seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl    (ctl),
        .phase  (phase),
        .step   (step),
        .ien    (ien),
        .halted (halted)
    );

    hwcs_decode dec_i (
        .phase    (phase),
        .step     (step),
        .op       (op),
        .mbr_ind  (mbr_ind),
        .mbr_zero (mbr_zero),
        .irq      (irq),
        .ien      (ien),
        .halted   (halted),
        .ctl      (ctl)
    );

    hwcs_dpath #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .op        (op),
        .mbr_ind   (mbr_ind),
        .mbr_zero  (mbr_zero),
        .pc        (dbg_pc),
        .mar       (dbg_mar),
        .mbr       (dbg_mbr),
        .ir        (dbg_ir),
        .r1        (dbg_r1)
    );

    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign dbg_phase = phase;
    assign dbg_step  = step;

endmodule

// File: rtl/hwcs_checker.sv
module hwcs_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        phase,
    input logic [1:0]        step,
    input logic [ADDR_W-1:0] pc,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              halted
);

    assert_rdwr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_wr_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> phase[1]);

    assert_step_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> (step == 2'd0));

    assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 && step == 2'd1) |=> (pc == $past(pc) + 1'b1));

    assert_int_from_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b11 && step == 2'd0) |-> ($past(phase) == 2'b10));

    assert_t4_exec_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 2'd3) |-> (phase == 2'b10));

    assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(phase) && !mem_wr));

endmodule

bind hw_ctrl_seq hwcs_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (dbg_phase),
    .step   (dbg_step),
    .pc     (dbg_pc),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .halted (halted)
);

// File: tb/hw_ctrl_seq_tb_top.sv
module hw_ctrl_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [1:0]  dbg_phase, dbg_step;
    logic [11:0] dbg_pc, dbg_mar;
    logic [15:0] dbg_mbr, dbg_ir, dbg_r1;
    logic        halted;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] sim_mem [0:255];
    logic [15:0] mdl_mem [0:255];
    int m_pc, m_r1;
    bit m_ien;
    int exp_q [$];

    always #4 clk = ~clk;

    hw_ctrl_seq dut_i (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dbg_phase(dbg_phase), .dbg_step(dbg_step), .dbg_pc(dbg_pc),
        .dbg_mar(dbg_mar), .dbg_mbr(dbg_mbr), .dbg_ir(dbg_ir),
        .dbg_r1(dbg_r1), .halted(halted)
    );

    // synchronous memory, one cycle read latency
    always @(posedge clk) begin
        if (mem_wr) sim_mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= sim_mem[mem_addr[7:0]];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10: strobes exclusive, sampled every cycle
    always @(negedge clk) begin
        if (rst_n && !done) check(!(mem_rd && mem_wr), "R10 rd/wr overlap", {mem_rd, mem_wr}, 0);
    end

    task automatic put(input int a, input int v);
        sim_mem[a] = 16'(v);
        mdl_mem[a] = 16'(v);
    endtask

    task automatic push_steps(input int ph, input int n);
        for (int s = 0; s < n; s++) exp_q.push_back(ph * 4 + s);
    endtask

    // behavioural instruction model: expected phase/step stream and state
    task automatic model_instr(input bit irq_lvl);
        int ins, op, a, w;
        ins = mdl_mem[m_pc & 255];
        push_steps(0, 3);
        m_pc = (m_pc + 1) & 'hFFF;
        op = ins >> 13;
        a = ins & 'hFFF;
        if ((ins >> 12) & 1) begin
            push_steps(1, 3);
            a = mdl_mem[a & 255] & 'hFFF;
        end
        case (op)
            0: begin push_steps(2, 3); m_r1 = (m_r1 + mdl_mem[a & 255]) & 'hFFFF; end
            1: begin
                push_steps(2, 4);
                w = (mdl_mem[a & 255] + 1) & 'hFFFF;
                mdl_mem[a & 255] = 16'(w);
                if (w == 0) m_pc = (m_pc + 1) & 'hFFF;
            end
            2: begin push_steps(2, 3); mdl_mem[a & 255] = 16'(m_pc); m_pc = (a + 1) & 'hFFF; end
            default: push_steps(2, 1);
        endcase
        if (op != 7 && irq_lvl && m_ien) begin
            push_steps(3, 3);
            mdl_mem[0] = 16'(m_pc);
            m_pc = 1;
            m_ien = 0;
        end
    endtask

    task automatic run_instr(input bit irq_lvl, input string req);
        int e, act, bad, first;
        irq = irq_lvl;
        model_instr(irq_lvl);
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            act = {dbg_phase, dbg_step};
            check(act == e, {(e < 4) ? "R2" : req, "/R9 phase.step"}, act, e);
            @(negedge clk);
        end
        irq = 1'b0;
        check(dbg_pc == 12'(m_pc), {req, " pc"}, dbg_pc, m_pc);
        check(dbg_r1 == 16'(m_r1), {req, " r1"}, dbg_r1, m_r1);
        bad = 0; first = 0;
        for (int i = 0; i < 256; i++)
            if (sim_mem[i] !== mdl_mem[i]) begin
                if (bad == 0) first = i;
                bad++;
            end
        check(bad == 0, {req, "/R10 memory mismatches at first addr"}, first, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) put(i, 0);
        // program: op<<13 | ind<<12 | addr
        put('h00, 'h4010);                  // BSA 0x10 -> continue at 0x11
        put('h01, 'h0040);                  // handler: ADD 0x40
        put('h02, 'h5047);                  // BSA indirect via 0x47
        put('h11, 'h0040);                  // ADD 0x40
        put('h12, 'h1041);                  // ADD indirect 0x41
        put('h13, 'h2043);                  // ISZ 0x43 (no skip)
        put('h14, 'h2043);                  // ISZ 0x43 (skip)
        put('h15, 'h0040);                  // skipped
        put('h16, 'h3044);                  // ISZ indirect 0x44
        put('h17, 'h0046);                  // ADD 0x46 (wraps), irq taken
        put('h40, 5);  put('h41, 'h42); put('h42, 7);
        put('h43, 'hFFFE); put('h44, 'h45); put('h45, 3);
        put('h46, 'hFFFF); put('h47, 'h50);
        put('h51, 'h6000);                  // opcode 3
        put('h52, 'hE000);                  // HALT
        m_pc = 0; m_r1 = 0; m_ien = 1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state visible before first edge after release
        check(dbg_phase == 2'b00, "R1 phase", dbg_phase, 0);
        check(dbg_step == 2'd0, "R1 step", dbg_step, 0);
        check(dbg_pc == 12'd0, "R1 pc", dbg_pc, 0);
        check(dbg_r1 == 16'd0 && dbg_mbr == 16'd0, "R1 r1/mbr", dbg_r1, 0);
        check(!halted, "R1 halted", halted, 0);

        run_instr(0, "R6");    // BSA direct
        run_instr(0, "R4");    // ADD direct
        run_instr(0, "R3");    // ADD indirect
        run_instr(0, "R5");    // ISZ without skip
        run_instr(0, "R5");    // ISZ reaching zero, skips
        run_instr(0, "R3");    // ISZ indirect
        run_instr(1, "R7");    // ADD with wrap (R4), interrupt entry
        check(sim_mem[0] == 16'h0018, "R7 saved return", sim_mem[0], 'h18);
        run_instr(1, "R8");    // irq high while disabled
        run_instr(0, "R6");    // BSA indirect
        run_instr(0, "R12");   // undefined opcode, no effect
        run_instr(0, "R11");   // HALT
        check(halted, "R11 halted high", halted, 1);
        irq = 1'b1;
        repeat (5) @(negedge clk);
        check(halted && dbg_phase == 2'b10 && dbg_step == 2'd0, "R11 phase/step hold",
              {dbg_phase, dbg_step}, 8);
        check(dbg_pc == 12'(m_pc), "R11 pc hold", dbg_pc, m_pc);
        irq = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule